// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the command front end of an eight-line priority interrupt controller. It takes byte writes and reads on a port with two addresses, chosen by `addr_sel`. It runs the multi-word initialization handshake and decodes the runtime command words. It holds every mode bit the rest of the controller consults: the mask, the vector base, auto end-of-interrupt, nested mode, rotate-on-auto-clear, the read selector, the poll request, the special mask and the rotation base.

Priority arbitration is outside this block. A resolver supplies two results:
- the highest-priority in-service line, on `top_insvc_vld` and `top_insvc_line`;
- the highest-priority unmasked request, on `top_req_vld` and `top_req_line`.

The sequencer turns end-of-interrupt commands into a one-cycle clear pulse on `clr_vld` and `clr_line`. It moves the rotation base when a rotating command asks for it. It pulses `init_start` so that the surrounding logic empties its request and in-service sets and drops the CPU request line.

Writes take effect at the rising edge that samples `wr_en`. Reads are combinational while `rd_en` is high.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the following are all zero: the mask, vector base, rotation base, every mode flag, the read selector and the poll request. `init_busy` is low.
- R2: A write at `addr_sel`=0 with data bit 4 set starts initialization. In the next cycle these are all zero: the mask, rotation base, auto-clear flag, nested flag, rotate-on-auto-clear flag, special mask, read selector, poll request and vector base. `init_start` is high for exactly that one cycle, and `init_busy` is high.
- R3: During initialization, writes at `addr_sel`=1 advance through the sequence. The first loads the vector base with the data's low three bits forced to zero. A second word follows only if bit 1 of the starting word was 0. A final mode word follows only if bit 0 of the starting word was 1. After the last word, `init_busy` drops.
- R4: The final mode word sets the nested flag from its bit 4 and the auto-clear flag from its bit 1.
- R5: With `init_busy` low, a write at `addr_sel`=1 loads the mask. While `init_busy` is high, writes at `addr_sel`=1 leave the mask unchanged.
- R6: A write at `addr_sel`=0 with bit 4 clear and bit 3 set is the status word:
  - bit 0 loads the read selector (1 = in-service, 0 = request), but only when bit 1 is set;
  - bit 2 loads the poll request;
  - bit 5 loads the special mask, but only when bit 6 is set.
- R7: A write at `addr_sel`=0 with bits 4 and 3 clear is a command word whose code is data[7:5]. Code 0 clears the rotate-on-auto-clear flag and code 4 sets it. Code 2 changes nothing and issues no clear.
- R8: Code 1 is the non-specific clear: it pulses `clr_vld` with `top_insvc_line`. Code 5 does the same and also sets the rotation base to that line plus one, modulo 8. Neither code does anything while `top_insvc_vld` is low.
- R9: Code 3 pulses a clear of line data[2:0]. Code 6 sets the rotation base to data[2:0] plus one, modulo 8, with no clear. Code 7 does both. The rotation base changes only in the cycle after a write.
- R10: A read at `addr_sel`=1 returns the mask. A read at `addr_sel`=0 with no poll pending returns `insvc_bits` when the read selector is 1, and `req_bits` when it is 0.
- R11: While a poll is pending, a read at `addr_sel`=0 behaves as follows:
  - with a request present, it returns 0x80 OR `top_req_line` and raises `poll_ack_vld` with that line;
  - with no request, it returns 0x00 and `poll_ack_vld` stays low;
  - either way, the poll request clears at the end of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr_sel | input | 1 | Port address bit |
| wdata | input | 8 | Write data |
| req_bits | input | 8 | Current request set, for reads |
| insvc_bits | input | 8 | Current in-service set, for reads |
| top_insvc_vld | input | 1 | Resolver found an in-service line |
| top_insvc_line | input | 3 | Highest-priority in-service line |
| top_req_vld | input | 1 | Resolver found an unmasked request |
| top_req_line | input | 3 | Highest-priority unmasked request |
| rdata | output | 8 | Read data |
| mask_bits | output | 8 | Mask register |
| vec_base | output | 8 | Vector base |
| auto_clr | output | 1 | Auto end-of-interrupt mode |
| nested_mode | output | 1 | Special fully nested mode |
| rot_auto | output | 1 | Rotate on auto end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| rot_base | output | 3 | Rotation base (lowest-priority line plus one) |
| init_start | output | 1 | One-cycle pulse after an initialization start |
| init_busy | output | 1 | Initialization sequence in progress |
| clr_vld | output | 1 | In-service clear pulse |
| clr_line | output | 3 | Line to clear |
| poll_ack_vld | output | 1 | Poll read consumed a request |
| poll_ack_line | output | 3 | Line consumed by the poll read |

## Verification
The checks assume that `wr_en` and `rd_en` are never high in the same cycle, and that the resolver inputs are stable while a command word is sampled. The bench drives every strobe for exactly one cycle from the falling edge. It changes the resolver inputs only while both strobes are low, so each clear pulse and rotation update can be traced to exactly one write. Mask changes are asserted only for cycles that follow a data-port write made during initialization, which the stimulus performs in order.

// File: rtl/pic_seq_pkg.sv
`timescale 1ns/1ps
package pic_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_RUN  = 2'd0,
      SEQ_BASE = 2'd1,
      SEQ_CASC = 2'd2,
      SEQ_MODE = 2'd3
   } seq_state_e;

   typedef enum logic [2:0] {
      CMD_ROT_OFF = 3'd0,
      CMD_NS_CLR  = 3'd1,
      CMD_IDLE    = 3'd2,
      CMD_SP_CLR  = 3'd3,
      CMD_ROT_ON  = 3'd4,
      CMD_NS_ROT  = 3'd5,
      CMD_SET_PRI = 3'd6,
      CMD_SP_ROT  = 3'd7
   } cmd_code_e;

   localparam int unsigned BIT_START  = 4;
   localparam int unsigned BIT_STATUS = 3;

endpackage

// File: rtl/pic_seq_init_fsm.sv
`timescale 1ns/1ps
module pic_seq_init_fsm
   import pic_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_single,
   input  logic start_want_mode,
   input  logic data_wr,
   output logic busy,
   output logic base_ld,
   output logic mode_ld,
   output logic mask_ld
);

   seq_state_e state_q;
   seq_state_e state_d;
   logic       single_q;
   logic       want_mode_q;

   always_comb begin
      state_d = state_q;
      if (start) begin
         state_d = SEQ_BASE;
      end else if (data_wr) begin
         unique case (state_q)
            SEQ_BASE: state_d = !single_q   ? SEQ_CASC :
                                want_mode_q ? SEQ_MODE : SEQ_RUN;
            SEQ_CASC: state_d = want_mode_q ? SEQ_MODE : SEQ_RUN;
            SEQ_MODE: state_d = SEQ_RUN;
            default:  state_d = SEQ_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SEQ_RUN;
         single_q    <= 1'b0;
         want_mode_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start) begin
            single_q    <= start_single;
            want_mode_q <= start_want_mode;
         end
      end
   end

   assign busy    = (state_q != SEQ_RUN);
   assign base_ld = data_wr && (state_q == SEQ_BASE);
   assign mode_ld = data_wr && (state_q == SEQ_MODE);
   assign mask_ld = data_wr && (state_q == SEQ_RUN);

endmodule

// File: rtl/pic_seq_cmd_dec.sv
`timescale 1ns/1ps
module pic_seq_cmd_dec
   import pic_seq_pkg::*;
#(
   parameter int unsigned LINE_W = 3
) (
   input  logic              cmd_wr,
   input  logic [2:0]        cmd,
   input  logic [LINE_W-1:0] dline,
   input  logic              top_vld,
   input  logic [LINE_W-1:0] top_line,
   output logic              clr_req,
   output logic [LINE_W-1:0] clr_line,
   output logic              rot_ld,
   output logic [LINE_W-1:0] rot_val,
   output logic              raut_ld,
   output logic              raut_val
);

   localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

   always_comb begin
      clr_req  = 1'b0;
      clr_line = dline;
      rot_ld   = 1'b0;
      rot_val  = dline + ONE;
      raut_ld  = 1'b0;
      raut_val = cmd[2];
      if (cmd_wr) begin
         unique case (cmd_code_e'(cmd))
            CMD_ROT_OFF, CMD_ROT_ON: raut_ld = 1'b1;
            CMD_NS_CLR, CMD_NS_ROT: begin
               clr_req  = top_vld;
               clr_line = top_line;
               rot_ld   = top_vld && cmd[2];
               rot_val  = top_line + ONE;
            end
            CMD_SP_CLR:  clr_req = 1'b1;
            CMD_SET_PRI: rot_ld  = 1'b1;
            CMD_SP_ROT: begin
               clr_req = 1'b1;
               rot_ld  = 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pic_seq_rd_mux.sv
`timescale 1ns/1ps
module pic_seq_rd_mux #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LINES  = 8,
   parameter int unsigned LINE_W = 3
) (
   input  logic              rd_en,
   input  logic              addr_sel,
   input  logic              poll_pend,
   input  logic              read_insvc,
   input  logic [LINES-1:0]  mask,
   input  logic [LINES-1:0]  req,
   input  logic [LINES-1:0]  insvc,
   input  logic              top_req_vld,
   input  logic [LINE_W-1:0] top_req_line,
   output logic [DATA_W-1:0] rdata,
   output logic              poll_take
);

   logic [DATA_W-1:0] mask_x;
   logic [DATA_W-1:0] req_x;
   logic [DATA_W-1:0] insvc_x;
   logic [DATA_W-1:0] poll_x;

   generate
      if (LINES < DATA_W) begin : g_pad
         assign mask_x  = {{(DATA_W-LINES){1'b0}}, mask};
         assign req_x   = {{(DATA_W-LINES){1'b0}}, req};
         assign insvc_x = {{(DATA_W-LINES){1'b0}}, insvc};
      end else begin : g_full
         assign mask_x  = mask;
         assign req_x   = req;
         assign insvc_x = insvc;
      end
   endgenerate

   assign poll_x = top_req_vld ?
                   {1'b1, {(DATA_W-1-LINE_W){1'b0}}, top_req_line} : '0;

   always_comb begin
      if (!rd_en)         rdata = '0;
      else if (addr_sel)  rdata = mask_x;
      else if (poll_pend) rdata = poll_x;
      else if (read_insvc) rdata = insvc_x;
      else                rdata = req_x;
   end

   assign poll_take = rd_en && !addr_sel && poll_pend && top_req_vld;

endmodule

// File: rtl/pic_cmd_seq.sv
`timescale 1ns/1ps
module pic_cmd_seq
   import pic_seq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LINES  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      rd_en,
   input  logic                      addr_sel,
   input  logic [DATA_W-1:0]         wdata,
   input  logic [LINES-1:0]          req_bits,
   input  logic [LINES-1:0]          insvc_bits,
   input  logic                      top_insvc_vld,
   input  logic [$clog2(LINES)-1:0]  top_insvc_line,
   input  logic                      top_req_vld,
   input  logic [$clog2(LINES)-1:0]  top_req_line,
   output logic [DATA_W-1:0]         rdata,
   output logic [LINES-1:0]          mask_bits,
   output logic [DATA_W-1:0]         vec_base,
   output logic                      auto_clr,
   output logic                      nested_mode,
   output logic                      rot_auto,
   output logic                      special_mask,
   output logic [$clog2(LINES)-1:0]  rot_base,
   output logic                      init_start,
   output logic                      init_busy,
   output logic                      clr_vld,
   output logic [$clog2(LINES)-1:0]  clr_line,
   output logic                      poll_ack_vld,
   output logic [$clog2(LINES)-1:0]  poll_ack_line
);

   localparam int unsigned LINE_W = $clog2(LINES);
   localparam logic [DATA_W-1:0] VEC_KEEP = ~DATA_W'((1 << LINE_W) - 1);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("pic_cmd_seq: command fields need an 8-bit data port");
      end
      if (LINES < 2 || LINES > 8 || (1 << LINE_W) != LINES) begin : g_bad_lines
         $error("pic_cmd_seq: LINES must be 2, 4 or 8");
      end
   endgenerate

   logic wr_cmd_port;
   logic wr_data_port;
   logic hit_start;
   logic hit_status;
   logic hit_cmd;

   assign wr_cmd_port  = wr_en && !addr_sel;
   assign wr_data_port = wr_en &&  addr_sel;
   assign hit_start    = wr_cmd_port &&  wdata[BIT_START];
   assign hit_status   = wr_cmd_port && !wdata[BIT_START] &&  wdata[BIT_STATUS];
   assign hit_cmd      = wr_cmd_port && !wdata[BIT_START] && !wdata[BIT_STATUS];

   logic base_ld;
   logic mode_ld;
   logic mask_ld;

   pic_seq_init_fsm u_init (
      .clk             (clk),
      .rst_n           (rst_n),
      .start           (hit_start),
      .start_single    (wdata[1]),
      .start_want_mode (wdata[0]),
      .data_wr         (wr_data_port),
      .busy            (init_busy),
      .base_ld         (base_ld),
      .mode_ld         (mode_ld),
      .mask_ld         (mask_ld)
   );

   logic              dec_clr;
   logic [LINE_W-1:0] dec_clr_line;
   logic              dec_rot_ld;
   logic [LINE_W-1:0] dec_rot_val;
   logic              dec_raut_ld;
   logic              dec_raut_val;

   pic_seq_cmd_dec #(.LINE_W(LINE_W)) u_dec (
      .cmd_wr   (hit_cmd),
      .cmd      (wdata[7:5]),
      .dline    (wdata[LINE_W-1:0]),
      .top_vld  (top_insvc_vld),
      .top_line (top_insvc_line),
      .clr_req  (dec_clr),
      .clr_line (dec_clr_line),
      .rot_ld   (dec_rot_ld),
      .rot_val  (dec_rot_val),
      .raut_ld  (dec_raut_ld),
      .raut_val (dec_raut_val)
   );

   logic [LINES-1:0]  mask_q;
   logic [DATA_W-1:0] vec_q;
   logic              aclr_q;
   logic              nest_q;
   logic              raut_q;
   logic              smask_q;
   logic              rsel_q;
   logic              poll_q;
   logic [LINE_W-1:0] rot_q;
   logic              clr_q;
   logic [LINE_W-1:0] clr_line_q;
   logic              init_q;
   logic              poll_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q     <= '0;
         vec_q      <= '0;
         aclr_q     <= 1'b0;
         nest_q     <= 1'b0;
         raut_q     <= 1'b0;
         smask_q    <= 1'b0;
         rsel_q     <= 1'b0;
         poll_q     <= 1'b0;
         rot_q      <= '0;
         clr_q      <= 1'b0;
         clr_line_q <= '0;
         init_q     <= 1'b0;
      end else begin
         clr_q      <= dec_clr;
         clr_line_q <= dec_clr_line;
         init_q     <= hit_start;
         if (rd_en && !addr_sel) poll_q <= 1'b0;
         if (hit_start) begin
            mask_q  <= '0;
            vec_q   <= '0;
            aclr_q  <= 1'b0;
            nest_q  <= 1'b0;
            raut_q  <= 1'b0;
            smask_q <= 1'b0;
            rsel_q  <= 1'b0;
            poll_q  <= 1'b0;
            rot_q   <= '0;
         end else begin
            if (mask_ld) mask_q <= wdata[LINES-1:0];
            if (base_ld) vec_q  <= wdata & VEC_KEEP;
            if (mode_ld) begin
               nest_q <= wdata[4];
               aclr_q <= wdata[1];
            end
            if (hit_status) begin
               poll_q <= wdata[2];
               if (wdata[1]) rsel_q  <= wdata[0];
               if (wdata[6]) smask_q <= wdata[5];
            end
            if (dec_rot_ld)  rot_q  <= dec_rot_val;
            if (dec_raut_ld) raut_q <= dec_raut_val;
         end
      end
   end

   pic_seq_rd_mux #(
      .DATA_W (DATA_W),
      .LINES  (LINES),
      .LINE_W (LINE_W)
   ) u_rd (
      .rd_en        (rd_en),
      .addr_sel     (addr_sel),
      .poll_pend    (poll_q),
      .read_insvc   (rsel_q),
      .mask         (mask_q),
      .req          (req_bits),
      .insvc        (insvc_bits),
      .top_req_vld  (top_req_vld),
      .top_req_line (top_req_line),
      .rdata        (rdata),
      .poll_take    (poll_take)
   );

   assign mask_bits     = mask_q;
   assign vec_base      = vec_q;
   assign auto_clr      = aclr_q;
   assign nested_mode   = nest_q;
   assign rot_auto      = raut_q;
   assign special_mask  = smask_q;
   assign rot_base      = rot_q;
   assign init_start    = init_q;
   assign clr_vld       = clr_q;
   assign clr_line      = clr_line_q;
   assign poll_ack_vld  = poll_take;
   assign poll_ack_line = top_req_line;

endmodule

// File: rtl/pic_cmd_seq_chk.sv
`timescale 1ns/1ps
module pic_cmd_seq_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LINES  = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic                     rd_en,
   input logic                     addr_sel,
   input logic [DATA_W-1:0]        wdata,
   input logic [LINES-1:0]         mask_bits,
   input logic [DATA_W-1:0]        vec_base,
   input logic [$clog2(LINES)-1:0] rot_base,
   input logic                     init_start,
   input logic                     init_busy,
   input logic                     clr_vld,
   input logic                     poll_ack_vld
);

   localparam int unsigned LINE_W = $clog2(LINES);

   // R8
   clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vld |-> $past(wr_en && !addr_sel && !wdata[4] && !wdata[3]));

   // R2
   init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_start |-> (mask_bits == '0 && rot_base == '0 && init_busy));

   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr_sel && init_busy) |=> $stable(mask_bits));

   // R3
   vec_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_base[LINE_W-1:0] == '0);

   // R11
   poll_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_ack_vld |-> (rd_en && !addr_sel));

   // R9
   rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(rot_base));

endmodule

bind pic_cmd_seq pic_cmd_seq_chk #(.DATA_W(DATA_W), .LINES(LINES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .addr_sel     (addr_sel),
   .wdata        (wdata),
   .mask_bits    (mask_bits),
   .vec_base     (vec_base),
   .rot_base     (rot_base),
   .init_start   (init_start),
   .init_busy    (init_busy),
   .clr_vld      (clr_vld),
   .poll_ack_vld (poll_ack_vld)
);

// File: tb/pic_cmd_seq_tb.sv
`timescale 1ns/1ps
module pic_cmd_seq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic       addr_sel = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] req_bits = '0;
   logic [7:0] insvc_bits = '0;
   logic       top_insvc_vld = 1'b0;
   logic [2:0] top_insvc_line = '0;
   logic       top_req_vld = 1'b0;
   logic [2:0] top_req_line = '0;
   logic [7:0] rdata;
   logic [7:0] mask_bits;
   logic [7:0] vec_base;
   logic       auto_clr;
   logic       nested_mode;
   logic       rot_auto;
   logic       special_mask;
   logic [2:0] rot_base;
   logic       init_start;
   logic       init_busy;
   logic       clr_vld;
   logic [2:0] clr_line;
   logic       poll_ack_vld;
   logic [2:0] poll_ack_line;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   pic_cmd_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr_sel(addr_sel), .wdata(wdata), .req_bits(req_bits),
      .insvc_bits(insvc_bits), .top_insvc_vld(top_insvc_vld),
      .top_insvc_line(top_insvc_line), .top_req_vld(top_req_vld),
      .top_req_line(top_req_line), .rdata(rdata), .mask_bits(mask_bits),
      .vec_base(vec_base), .auto_clr(auto_clr), .nested_mode(nested_mode),
      .rot_auto(rot_auto), .special_mask(special_mask), .rot_base(rot_base),
      .init_start(init_start), .init_busy(init_busy), .clr_vld(clr_vld),
      .clr_line(clr_line), .poll_ack_vld(poll_ack_vld),
      .poll_ack_line(poll_ack_line)
   );

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr_sel = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d,
                     output logic ack, output logic [2:0] ack_line);
      @(negedge clk);
      rd_en = 1'b1; addr_sel = a;
      #1;
      d = rdata; ack = poll_ack_vld; ack_line = poll_ack_line;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 mask", 32'(mask_bits), 0);
      check("R1 vec", 32'(vec_base), 0);
      check("R1 rot", 32'(rot_base), 0);
      check("R1 flags", {auto_clr, nested_mode, rot_auto, special_mask}, 0);
      check("R1 busy", 32'(init_busy), 0);
   endtask

   task automatic t_init_full();
      wr(1'b0, 8'h11);
      check("R2 start pulse", 32'(init_start), 1);
      check("R2 busy", 32'(init_busy), 1);
      @(negedge clk);
      check("R2 pulse single", 32'(init_start), 0);
      wr(1'b1, 8'h4D);
      check("R3 vec base", 32'(vec_base), 32'h48);
      check("R3 still busy", 32'(init_busy), 1);
      wr(1'b1, 8'hFF);
      check("R5 mask kept in init", 32'(mask_bits), 0);
      check("R3 awaiting mode", 32'(init_busy), 1);
      wr(1'b1, 8'h12);
      check("R4 nested", 32'(nested_mode), 1);
      check("R4 auto", 32'(auto_clr), 1);
      check("R3 done", 32'(init_busy), 0);
   endtask

   task automatic t_mask_read();
      logic [7:0] d; logic a; logic [2:0] l;
      wr(1'b1, 8'h3C);
      check("R5 mask load", 32'(mask_bits), 32'h3C);
      rd(1'b1, d, a, l);
      check("R10 mask read", 32'(d), 32'h3C);
   endtask

   task automatic t_status();
      logic [7:0] d; logic a; logic [2:0] l;
      req_bits = 8'h81; insvc_bits = 8'h24;
      rd(1'b0, d, a, l);
      check("R10 req read", 32'(d), 32'h81);
      wr(1'b0, 8'h0B);
      rd(1'b0, d, a, l);
      check("R10 insvc read", 32'(d), 32'h24);
      wr(1'b0, 8'h0A);
      wr(1'b0, 8'h09);
      rd(1'b0, d, a, l);
      check("R6 select needs bit1", 32'(d), 32'h81);
      wr(1'b0, 8'h68);
      check("R6 smask set", 32'(special_mask), 1);
      wr(1'b0, 8'h28);
      check("R6 smask needs bit6", 32'(special_mask), 1);
      wr(1'b0, 8'h48);
      check("R6 smask clear", 32'(special_mask), 0);
   endtask

   task automatic t_rot_flag();
      wr(1'b0, 8'h80);
      check("R7 code4", 32'(rot_auto), 1);
      wr(1'b0, 8'h40);
      check("R7 code2 flag", 32'(rot_auto), 1);
      check("R7 code2 no clr", 32'(clr_vld), 0);
      check("R7 code2 rot", 32'(rot_base), 0);
      wr(1'b0, 8'h00);
      check("R7 code0", 32'(rot_auto), 0);
   endtask

   task automatic t_eoi();
      top_insvc_vld = 1'b1; top_insvc_line = 3'd5;
      wr(1'b0, 8'h20);
      check("R8 ns clr", 32'({clr_vld, clr_line}), 32'({1'b1, 3'd5}));
      check("R8 ns no rot", 32'(rot_base), 0);
      @(negedge clk);
      check("R8 pulse one cycle", 32'(clr_vld), 0);
      wr(1'b0, 8'hA0);
      check("R8 nsrot clr", 32'({clr_vld, clr_line}), 32'({1'b1, 3'd5}));
      check("R8 nsrot base", 32'(rot_base), 6);
      top_insvc_line = 3'd7;
      wr(1'b0, 8'hA0);
      check("R8 nsrot wrap", 32'(rot_base), 0);
      top_insvc_vld = 1'b0;
      wr(1'b0, 8'hA0);
      check("R8 none in service", 32'(clr_vld), 0);
      check("R8 none rot kept", 32'(rot_base), 0);
      wr(1'b0, 8'h62);
      check("R9 specific", 32'({clr_vld, clr_line}), 32'({1'b1, 3'd2}));
      wr(1'b0, 8'hC3);
      check("R9 set pri base", 32'(rot_base), 4);
      check("R9 set pri no clr", 32'(clr_vld), 0);
      wr(1'b0, 8'hE4);
      check("R9 rot specific clr", 32'({clr_vld, clr_line}), 32'({1'b1, 3'd4}));
      check("R9 rot specific base", 32'(rot_base), 5);
      wr(1'b0, 8'hC7);
      check("R9 set pri wrap", 32'(rot_base), 0);
   endtask

   task automatic t_poll();
      logic [7:0] d; logic a; logic [2:0] l;
      top_req_vld = 1'b1; top_req_line = 3'd6;
      wr(1'b0, 8'h0C);
      rd(1'b0, d, a, l);
      check("R11 poll data", 32'(d), 32'h86);
      check("R11 poll ack", 32'({a, l}), 32'({1'b1, 3'd6}));
      rd(1'b0, d, a, l);
      check("R11 poll consumed", 32'(d), 32'h81);
      check("R11 no second ack", 32'(a), 0);
      top_req_vld = 1'b0;
      wr(1'b0, 8'h0C);
      rd(1'b0, d, a, l);
      check("R11 empty poll", 32'(d), 0);
      check("R11 empty no ack", 32'(a), 0);
   endtask

   task automatic t_init_short();
      wr(1'b1, 8'hA5);
      wr(1'b0, 8'hC3);
      wr(1'b0, 8'h80);
      check("R9 base before init", 32'(rot_base), 4);
      wr(1'b0, 8'h12);
      check("R2 mask cleared", 32'(mask_bits), 0);
      check("R2 rot cleared", 32'(rot_base), 0);
      check("R2 modes cleared", {auto_clr, nested_mode, rot_auto}, 0);
      wr(1'b1, 8'h27);
      check("R3 short vec", 32'(vec_base), 32'h20);
      check("R3 short done", 32'(init_busy), 0);
      wr(1'b1, 8'h5A);
      check("R5 mask after short", 32'(mask_bits), 32'h5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_init_full();
      t_mask_read();
      t_status();
      t_rot_flag();
      t_eoi();
      t_poll();
      t_init_short();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule